// File: doc/BRIEF.md
# Windowed Integer Register File with Per-Register Parity

This block is the general-purpose register store of a 32-bit integer core that uses overlapping register windows. It has 136 physical registers. Eight of them are globals that every window sees. The other 128 form a ring of eight windows, with sixteen unique registers per window. Software addresses 32 architectural registers through the current window pointer. Within a window, register 0 is a constant zero, 1 to 7 are the globals, 8 to 15 are the outgoing registers, 16 to 23 are the locals and 24 to 31 are the incoming registers. The incoming registers of window w are the same storage as the outgoing registers of window w+1, wrapping from the last window to window 0.

The file has one write port and two combinational read ports, and it is read every cycle. Each register stores an odd-parity check bit alongside its data, computed from the write data in the same clock edge. A read port reports a parity mismatch only when its operand-used qualifier is high, so unused operands never raise an error. Reset clears every cell to all-zero data with a zero check bit, which is not valid odd parity. A register that is consumed before software has written it is therefore flagged. When either port flags an error, the block raises a trap request carrying the register-file error code 0x64. The pipeline sequences that trap elsewhere.

Top module: `winreg_parity_file`

## Requirements
- R1: The file holds 8 global cells (architectural 0 to 7) shared by every window. At window w, an architectural register a in 8..31 maps to physical cell ((w*16 + a - 8) mod 128) + 8, so all 136 cells are reachable.
- R2: Architectural registers 24..31 at window w address the same cells as architectural registers 8..15 at window (w+1) mod 8, including the wrap from window 7 to window 0.
- R3: The locals (16..23) of each window and the outgoing registers of each window are distinct cells. Writing one of them never changes a register that maps to a different cell.
- R4: A write with wr_en high updates the cell at the next rising clock edge. Reads are combinational from the current cwp and read address.
- R5: Every write stores an odd-parity bit computed from the write data, so the 33 stored bits hold an odd count of ones. A used read of a written cell reports no error.
- R6: rd_a_perr and rd_b_perr stay low whenever the corresponding used qualifier is low, whatever the stored contents.
- R7: Reset clears all cells to zero data and a zero check bit. After reset, a used read of any never-written register other than 0 returns zero data with its parity error high.
- R8: Architectural register 0 always reads as zero with no parity error. Writes to it are discarded.
- R9: When a port reads the register that is being written in the same cycle, it returns the write data and reports no error (write-through).
- R10: trap_req is high exactly when either read port reports a parity error. trap_code is 0x64 while trap_req is high and 0x00 otherwise.
- R11: The two read ports are independent. Each reports its own data and its own error for its own address and qualifier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; clears all cells |
| cwp | input | 3 | Current window pointer, shared by all ports |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Architectural write register |
| wr_data | input | 32 | Write data |
| rd_a_addr | input | 5 | Architectural register on read port A |
| rd_a_used | input | 1 | Port A operand is consumed this cycle |
| rd_a_data | output | 32 | Port A read data |
| rd_a_perr | output | 1 | Port A parity error |
| rd_b_addr | input | 5 | Architectural register on read port B |
| rd_b_used | input | 1 | Port B operand is consumed this cycle |
| rd_b_data | output | 32 | Port B read data |
| rd_b_perr | output | 1 | Port B parity error |
| trap_req | output | 1 | Register-file error trap request |
| trap_code | output | 8 | Trap type, 0x64 while trap_req is high |

## Verification
The bench fills every global and every windowed cell in every window with a value derived from its physical index. It then reads all 32 architectural registers in all eight windows on both ports. A mapping error that aliases the wrong window, or fails to wrap window 7 into window 0, returns another cell's value. Unwritten cells are probed right after reset, both with and without the used qualifier. An even-parity or ungated checker would then either miss the error or raise it on idle ports. Register 0 writes, same-cycle write and read, and the trap code with and without an error are each checked. These catch a file that lets register 0 keep data, returns stale data on a collision, or leaves a code on the trap bus while no trap is requested.

// File: rtl/rfp_pkg.sv
`timescale 1ns/1ps
package rfp_pkg;

    localparam int ARCH_W   = 5;
    localparam int NGLOB    = 8;
    localparam int WIN_UNIQ = 16;
    localparam int NRD      = 2;
    localparam int TRAP_W   = 8;
    localparam logic [TRAP_W-1:0] TRAP_RF_PARITY = 8'h64;

    typedef logic [ARCH_W-1:0] arch_idx_t;

    typedef enum logic [1:0] {
        RC_ZERO     = 2'd0,
        RC_GLOBAL   = 2'd1,
        RC_WINDOWED = 2'd2
    } reg_class_e;

    function automatic reg_class_e classify(arch_idx_t a);
        if (a == '0)
            return RC_ZERO;
        else if (int'(a) < NGLOB)
            return RC_GLOBAL;
        else
            return RC_WINDOWED;
    endfunction

    // odd parity over a zero-extended word: zero padding leaves the xor unchanged
    function automatic logic odd_par(logic [63:0] d);
        return ~(^d);
    endfunction

    function automatic logic odd_ok(logic [63:0] d, logic p);
        return (^d) ^ p;
    endfunction

endpackage

// File: rtl/rf_win_map.sv
`timescale 1ns/1ps
module rf_win_map
    import rfp_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int CWP_W  = 3,
    parameter int PHYS_W = 8
) (
    input  logic [CWP_W-1:0]  cwp,
    input  arch_idx_t         arch,
    output logic [PHYS_W-1:0] phys
);
    localparam int RING = NWIN * WIN_UNIQ;

    int unsigned ring_pos;

    always_comb begin
        ring_pos = 0;
        if (classify(arch) == RC_WINDOWED) begin
            ring_pos = (int'(cwp) * WIN_UNIQ + int'(arch) - NGLOB) % RING;
            phys     = PHYS_W'(ring_pos + NGLOB);
        end else begin
            phys     = PHYS_W'(arch);
        end
    end
endmodule

// File: rtl/rf_cell_array.sv
`timescale 1ns/1ps
module rf_cell_array
    import rfp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NPHYS  = 136,
    parameter int PHYS_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PHYS_W-1:0] waddr,
    input  logic [DATA_W:0]   wcell,
    input  logic [PHYS_W-1:0] raddr [NRD],
    output logic [DATA_W:0]   rcell [NRD]
);
    logic [DATA_W:0] cells [NPHYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPHYS; i++)
                cells[i] <= '0;
        end else if (we) begin
            cells[waddr] <= wcell;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rcell[p] = cells[raddr[p]];
    end
endmodule

// File: rtl/rf_port_check.sv
`timescale 1ns/1ps
module rf_port_check
    import rfp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  arch_idx_t         arch,
    input  logic              used,
    input  logic [DATA_W:0]   cell_q,
    input  logic              wr_hit,
    input  logic [DATA_W:0]   wr_cell,
    output logic [DATA_W-1:0] data,
    output logic              perr
);
    logic [DATA_W:0] eff;

    always_comb begin
        if (classify(arch) == RC_ZERO)
            eff = {odd_par(64'd0), {DATA_W{1'b0}}};
        else if (wr_hit)
            eff = wr_cell;
        else
            eff = cell_q;
        data = eff[DATA_W-1:0];
        perr = used && !odd_ok(64'(eff[DATA_W-1:0]), eff[DATA_W]);
    end
endmodule

// File: rtl/rf_trap_req.sv
`timescale 1ns/1ps
module rf_trap_req
    import rfp_pkg::*;
(
    input  logic [NRD-1:0]    perr,
    output logic              req,
    output logic [TRAP_W-1:0] code
);
    always_comb begin
        req  = |perr;
        code = req ? TRAP_RF_PARITY : '0;
    end
endmodule

// File: rtl/winreg_parity_file.sv
`timescale 1ns/1ps
module winreg_parity_file
    import rfp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NWIN   = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [$clog2(NWIN)-1:0] cwp,
    input  logic                    wr_en,
    input  logic [4:0]              wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [4:0]              rd_a_addr,
    input  logic                    rd_a_used,
    output logic [DATA_W-1:0]       rd_a_data,
    output logic                    rd_a_perr,
    input  logic [4:0]              rd_b_addr,
    input  logic                    rd_b_used,
    output logic [DATA_W-1:0]       rd_b_data,
    output logic                    rd_b_perr,
    output logic                    trap_req,
    output logic [7:0]              trap_code
);
    localparam int CWP_W  = $clog2(NWIN);
    localparam int NPHYS  = NGLOB + NWIN * WIN_UNIQ;
    localparam int PHYS_W = $clog2(NPHYS);
    localparam int NMAP   = NRD + 1;

    arch_idx_t         map_arch [NMAP];
    logic [PHYS_W-1:0] map_phys [NMAP];
    logic [PHYS_W-1:0] rd_phys  [NRD];
    logic [DATA_W:0]   rd_cell  [NRD];
    logic              rd_used  [NRD];
    logic [DATA_W-1:0] rd_data  [NRD];
    logic [NRD-1:0]    rd_perr;
    logic [DATA_W:0]   wr_cell;
    logic              we_eff;

    assign map_arch[0] = wr_addr;
    assign map_arch[1] = rd_a_addr;
    assign map_arch[2] = rd_b_addr;
    assign rd_used[0]  = rd_a_used;
    assign rd_used[1]  = rd_b_used;

    for (genvar m = 0; m < NMAP; m++) begin : g_map
        rf_win_map #(.NWIN(NWIN), .CWP_W(CWP_W), .PHYS_W(PHYS_W)) map_i (
            .cwp  (cwp),
            .arch (map_arch[m]),
            .phys (map_phys[m])
        );
    end

    assign we_eff  = wr_en && (classify(wr_addr) != RC_ZERO);
    assign wr_cell = {odd_par(64'(wr_data)), wr_data};

    for (genvar p = 0; p < NRD; p++) begin : g_port
        assign rd_phys[p] = map_phys[p+1];
        rf_port_check #(.DATA_W(DATA_W)) chk_i (
            .arch    (map_arch[p+1]),
            .used    (rd_used[p]),
            .cell_q  (rd_cell[p]),
            .wr_hit  (we_eff && (map_phys[0] == map_phys[p+1])),
            .wr_cell (wr_cell),
            .data    (rd_data[p]),
            .perr    (rd_perr[p])
        );
    end

    rf_cell_array #(.DATA_W(DATA_W), .NPHYS(NPHYS), .PHYS_W(PHYS_W)) store_i (
        .clk   (clk),
        .rst   (rst),
        .we    (we_eff),
        .waddr (map_phys[0]),
        .wcell (wr_cell),
        .raddr (rd_phys),
        .rcell (rd_cell)
    );

    rf_trap_req trap_i (
        .perr (rd_perr),
        .req  (trap_req),
        .code (trap_code)
    );

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];
    assign rd_a_perr = rd_perr[0];
    assign rd_b_perr = rd_perr[1];
endmodule

// File: rtl/rf_par_checker.sv
`timescale 1ns/1ps
module rf_par_checker #(
    parameter int DATA_W = 32,
    parameter int CWP_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [CWP_W-1:0]  cwp,
    input logic              wr_en,
    input logic [4:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [4:0]        rd_a_addr,
    input logic              rd_a_used,
    input logic [DATA_W-1:0] rd_a_data,
    input logic              rd_a_perr,
    input logic [4:0]        rd_b_addr,
    input logic              rd_b_used,
    input logic [DATA_W-1:0] rd_b_data,
    input logic              rd_b_perr,
    input logic              trap_req,
    input logic [7:0]        trap_code
);
    a_r8_zero_a: assert property (@(posedge clk) disable iff (rst)
        (rd_a_addr == 5'd0) |-> (rd_a_data == '0 && !rd_a_perr));
    a_r8_zero_b: assert property (@(posedge clk) disable iff (rst)
        (rd_b_addr == 5'd0) |-> (rd_b_data == '0 && !rd_b_perr));

    a_r6_quiet_a: assert property (@(posedge clk) disable iff (rst)
        !rd_a_used |-> !rd_a_perr);
    a_r6_quiet_b: assert property (@(posedge clk) disable iff (rst)
        !rd_b_used |-> !rd_b_perr);

    a_r10_code_on_req: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> (trap_code == 8'h64 && (rd_a_perr || rd_b_perr)));
    a_r10_req_on_err: assert property (@(posedge clk) disable iff (rst)
        (rd_a_perr || rd_b_perr) |-> trap_req);
    a_r10_idle_code: assert property (@(posedge clk) disable iff (rst)
        !trap_req |-> (trap_code == 8'h00));

    a_r9_bypass_a: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != 5'd0 && wr_addr == rd_a_addr)
        |-> (rd_a_data == wr_data && !rd_a_perr));

    a_r4_write_seen_a: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(wr_en) && $past(wr_addr) != 5'd0 &&
         $past(wr_addr) == rd_a_addr && $past(cwp) == cwp && !wr_en)
        |-> (rd_a_data == $past(wr_data) && !rd_a_perr));

    a_r2_alias_a: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(wr_en) && $past(wr_addr) >= 5'd24 &&
         rd_a_addr == 5'($past(wr_addr) - 5'd16) &&
         cwp == CWP_W'($past(cwp) + 1'b1) && !wr_en)
        |-> (rd_a_data == $past(wr_data)));

    a_r7_fresh_a: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && rd_a_used && rd_a_addr != 5'd0 &&
         !(wr_en && wr_addr == rd_a_addr))
        |-> (rd_a_perr && rd_a_data == '0));
endmodule

bind winreg_parity_file rf_par_checker #(.DATA_W(DATA_W), .CWP_W(CWP_W)) par_chk_i (
    .clk       (clk),
    .rst       (rst),
    .cwp       (cwp),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_a_addr (rd_a_addr),
    .rd_a_used (rd_a_used),
    .rd_a_data (rd_a_data),
    .rd_a_perr (rd_a_perr),
    .rd_b_addr (rd_b_addr),
    .rd_b_used (rd_b_used),
    .rd_b_data (rd_b_data),
    .rd_b_perr (rd_b_perr),
    .trap_req  (trap_req),
    .trap_code (trap_code)
);

// File: tb/winreg_parity_file_tb_top.sv
`timescale 1ns/1ps
module winreg_parity_file_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cwp = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_a_addr = '0;
    logic        rd_a_used = 1'b0;
    logic [31:0] rd_a_data;
    logic        rd_a_perr;
    logic [4:0]  rd_b_addr = '0;
    logic        rd_b_used = 1'b0;
    logic [31:0] rd_b_data;
    logic        rd_b_perr;
    logic        trap_req;
    logic [7:0]  trap_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] shadow [136];

    always #2 clk = ~clk;

    winreg_parity_file dut_i (
        .clk(clk), .rst(rst), .cwp(cwp),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_a_addr(rd_a_addr), .rd_a_used(rd_a_used),
        .rd_a_data(rd_a_data), .rd_a_perr(rd_a_perr),
        .rd_b_addr(rd_b_addr), .rd_b_used(rd_b_used),
        .rd_b_data(rd_b_data), .rd_b_perr(rd_b_perr),
        .trap_req(trap_req), .trap_code(trap_code)
    );

    function automatic int bphys(int c, int a);
        if (a < 8) return a;
        return ((c * 16 + a - 8) % 128) + 8;
    endfunction

    function automatic logic [31:0] pattern(int p);
        return 32'h9E3779B9 * 32'(p + 1) ^ 32'(p << 24);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(int c, int a, logic [31:0] d);
        @(negedge clk);
        cwp = 3'(c); wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
        if (a != 0) shadow[bphys(c, a)] = d;
    endtask

    task automatic set_reads(int c, int aa, bit au, int ba, bit bu);
        @(negedge clk);
        cwp = 3'(c);
        rd_a_addr = 5'(aa); rd_a_used = au;
        rd_b_addr = 5'(ba); rd_b_used = bu;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 136; i++) shadow[i] = '0;
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 136; i++) shadow[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R7 fresh cell used on A, B unused (R6, R11, R10)
        set_reads(0, 5, 1, 9, 0);
        check("R7 fresh data", rd_a_data, 32'h0);
        check("R7 fresh perr", 32'(rd_a_perr), 32'd1);
        check("R6 b unused quiet", 32'(rd_b_perr), 32'd0);
        check("R10 trap req", 32'(trap_req), 32'd1);
        check("R10 trap code", 32'(trap_code), 32'h64);
        set_reads(0, 5, 0, 17, 1);
        check("R11 a unused quiet", 32'(rd_a_perr), 32'd0);
        check("R11 b fresh perr", 32'(rd_b_perr), 32'd1);
        check("R10 trap from b", 32'(trap_req), 32'd1);
        set_reads(0, 5, 0, 17, 0);
        check("R6 both unused no trap", 32'(trap_req), 32'd0);
        check("R10 idle code", 32'(trap_code), 32'h00);
        set_reads(0, 0, 1, 0, 1);
        check("R8 zero data", rd_a_data, 32'h0);
        check("R8 zero perr", 32'(rd_a_perr | rd_b_perr), 32'd0);

        // R8 write to register 0 is discarded
        do_write(0, 0, 32'hDEADBEEF);
        set_reads(0, 0, 1, 0, 1);
        check("R8 discard a", rd_a_data, 32'h0);
        check("R8 discard b", rd_b_data, 32'h0);

        // R9 same-cycle write and read
        @(negedge clk);
        cwp = 3'd2; wr_en = 1'b1; wr_addr = 5'd20; wr_data = 32'h1234ABCD;
        rd_a_addr = 5'd20; rd_a_used = 1'b1; rd_b_addr = 5'd21; rd_b_used = 1'b1;
        #1;
        check("R9 bypass data", rd_a_data, 32'h1234ABCD);
        check("R9 bypass perr", 32'(rd_a_perr), 32'd0);
        check("R11 other port fresh perr", 32'(rd_b_perr), 32'd1);
        @(posedge clk);
        #1 wr_en = 1'b0;
        shadow[bphys(2, 20)] = 32'h1234ABCD;
        set_reads(2, 20, 1, 0, 0);
        check("R4 stored after edge", rd_a_data, 32'h1234ABCD);

        // Fill every cell: globals, then outs and locals of each window
        for (int g = 1; g < 8; g++) do_write(0, g, pattern(g));
        for (int c = 0; c < 8; c++)
            for (int a = 8; a < 24; a++)
                do_write(c, a, pattern(bphys(c, a)));

        // R1 R3 R5 full sweep on both ports
        for (int c = 0; c < 8; c++) begin
            for (int a = 0; a < 32; a++) begin
                set_reads(c, a, 1, 31 - a, 1);
                check("R1 R3 sweep a data", rd_a_data, shadow[bphys(c, a)]);
                check("R1 R3 sweep b data", rd_b_data, shadow[bphys(c, 31 - a)]);
                check("R5 sweep perr", 32'({rd_a_perr, rd_b_perr}), 32'd0);
            end
        end

        // R2 alias and wrap
        do_write(3, 26, 32'hCAFE0326);
        set_reads(4, 10, 1, 26, 1);
        check("R2 ins to next outs", rd_a_data, 32'hCAFE0326);
        check("R3 next ins untouched", rd_b_data, pattern(bphys(5, 10)));
        do_write(7, 31, 32'h0707F00D);
        set_reads(0, 15, 1, 31, 1);
        check("R2 wrap 7 to 0", rd_a_data, 32'h0707F00D);
        check("R2 window0 ins", rd_b_data, pattern(bphys(1, 15)));

        // R1 globals shared across windows
        do_write(5, 3, 32'h600D0003);
        set_reads(1, 3, 1, 3, 0);
        check("R1 global shared", rd_a_data, 32'h600D0003);

        // R7 reset clears written cells
        do_reset();
        set_reads(2, 20, 1, 3, 1);
        check("R7 cleared data", rd_a_data, 32'h0);
        check("R7 cleared perr a", 32'(rd_a_perr), 32'd1);
        check("R7 cleared perr b", 32'(rd_b_perr), 32'd1);
        check("R10 code after reset", 32'(trap_code), 32'h64);

        // R5 zero-valued write carries odd parity
        do_write(6, 12, 32'h0);
        set_reads(6, 12, 1, 12, 1);
        check("R5 zero value no perr", 32'(rd_a_perr | rd_b_perr), 32'd0);
        check("R10 no trap when clean", 32'(trap_req), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule